// File: doc/BRIEF.md
# Multi-bank flash bus front end

This block is the device-side bus front end of a parallel flash memory. The host drives chip enable, write enable and output enable with no relation to the internal clock. The block oversamples those strobes and turns them into clean bus cycles. It decodes each cycle as standby, idle, read or write. Write cycles hand a command address and command data to a downstream command decoder. Reads are served from an eight-word page buffer that is filled from a read-only array model. In that model, the word at address A is (A*40503 + 4660) mod 2^DW.

The block keeps a record of the one bank that is running a program or erase. The command decoder raises `op_start` to mark the bank of the last captured command address as busy, and `op_done` when that operation ends. While a bank is busy, reads to any other bank return array data as usual. A read to the busy bank returns a fixed status word. A write aimed at a different bank is refused.

The control state machine has four states, and every clock it moves to the state picked by the synchronised strobes:
- S_STBY when chip enable is high.
- S_WRITE when chip enable and write enable are low.
- S_READ when chip enable and output enable are low and write enable is high.
- S_IDLE when chip enable is low with neither of the other two.

Entering S_WRITE from any other state is "write start". Leaving S_WRITE is "write end". A stay in S_IDLE counts cycles toward automatic standby.

Top module: `fbus_front`

## Requirements
- R1: Every host input passes through two flip-flops. The state, and every output derived from it, reflects the host inputs sampled two clock edges earlier.
- R2: `cmd_addr` takes the address present when chip enable and write enable are first both low, which is the later of their two falling edges.
- R3: At write end, `cmd_data` takes the data present when the first of the two strobes returns high. One of `cmd_valid`, `cmd_reject` or `proto_err` pulses for exactly one cycle.
- R4: If output enable is seen low in any cycle of a write, the write ends with `proto_err` instead of `cmd_valid`. This outcome takes priority over a bank conflict.
- R5: `data_oe` is high only in S_READ (chip enable low, output enable low, write enable high). It is low whenever output enable is high.
- R6: `standby` is high in S_STBY. It is also high after AUTO_CYC consecutive clock edges spent in S_IDLE (automatic standby). `data_oe` is then low.
- R7: In S_READ, a read whose address bits above bit 2 differ from the loaded page reloads all 8 words in one cycle. `data_rdy` then rises and `data_out` shows the page word picked by address bits [2:0]. `data_out` is 0 whenever `data_rdy` is low.
- R8: While a bank is busy, reads to the other banks return the array word.
- R9: A read to the busy bank returns BUSY_WORD (default 16'h0080). The bank is the top two address bits.
- R10: While a bank is busy, a write whose command address lies in another bank ends with `cmd_reject`. A write to the busy bank ends with `cmd_valid`.
- R11: `op_start` with no bank busy sets `busy` and loads `busy_bank` from the bank of `cmd_addr`. `op_start` while busy is ignored. `op_done` clears `busy` and wins over `op_start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Host address |
| data_in | input | DW | Host write data |
| op_start | input | 1 | Decoder marks the bank of `cmd_addr` busy |
| op_done | input | 1 | Decoder ends the running bank operation |
| data_out | output | DW | Read data toward the pads |
| data_oe | output | 1 | Pad output enable (0 = high impedance) |
| data_rdy | output | 1 | `data_out` holds valid read data |
| standby | output | 1 | Standby or automatic standby |
| cmd_valid | output | 1 | Accepted write command pulse |
| cmd_reject | output | 1 | Write refused because of a bank conflict |
| proto_err | output | 1 | Write seen with output enable low |
| cmd_addr | output | AW | Captured command address |
| cmd_data | output | DW | Captured command data |
| busy | output | 1 | A bank operation is running |
| busy_bank | output | 2 | Bank of the running operation |

## Verification
A wrong state shows on `data_oe` and `standby` at the very next sampled cycle, because both come straight from the state register. A missed or spurious write start shows up as a wrong `cmd_addr`, or as a missing or extra pulse one cycle after the strobes are seen released. A stale page tag, or wrong busy bookkeeping, shows on `data_out` and `data_rdy` in the first read cycle after the change. Two cases are each walked through explicitly: a write where write enable falls before chip enable, and a write to a second bank while another bank is busy.

// File: rtl/fbus_pkg.sv
package fbus_pkg;

    typedef enum logic [1:0] {
        S_STBY  = 2'd0,
        S_IDLE  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } bus_state_t;

    // Contents of the read-only array model
    function automatic logic [31:0] array_word(input logic [31:0] a);
        return a * 32'd40503 + 32'd4660;
    endfunction

endpackage

// File: rtl/fbus_sync.sv
module fbus_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST;
            q      <= RST;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fbus_bank.sv
module fbus_bank #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          done,
    input  logic [BW-1:0] start_bank,
    output logic          busy,
    output logic [BW-1:0] busy_bank
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            busy_bank <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (start && !busy) begin
            busy      <= 1'b1;
            busy_bank <= start_bank;
        end
    end

    AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy && $stable(busy_bank)); // R11
endmodule

// File: rtl/fbus_page.sv
module fbus_page #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic [AW-1:0] rd_addr,
    output logic          hit,
    output logic [DW-1:0] rd_word
);
    localparam int PW = 3;
    localparam int TW = AW - PW;
    localparam int PAGE_WORDS = 1 << PW;

    logic [DW-1:0] buf_q [PAGE_WORDS];
    logic [TW-1:0] tag_q;
    logic          valid_q;

    assign hit     = valid_q && (tag_q == rd_addr[AW-1:PW]);
    assign rd_word = buf_q[rd_addr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            for (int i = 0; i < PAGE_WORDS; i++) buf_q[i] <= '0;
        end else if (fill_en && !hit) begin
            valid_q <= 1'b1;
            tag_q   <= rd_addr[AW-1:PW];
            for (int i = 0; i < PAGE_WORDS; i++)
                buf_q[i] <= DW'(fbus_pkg::array_word(32'({rd_addr[AW-1:PW], PW'(i)})));
        end
    end

    AST_PAGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !hit |=> valid_q && (tag_q == $past(rd_addr[AW-1:PW]))); // R7
endmodule

// File: rtl/fbus_front.sv
module fbus_front #(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int BANKS = 4,
    parameter int AUTO_CYC = 16,
    parameter logic [DW-1:0] BUSY_WORD = 16'h0080
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            data_in,
    input  logic                     op_start,
    input  logic                     op_done,
    output logic [DW-1:0]            data_out,
    output logic                     data_oe,
    output logic                     data_rdy,
    output logic                     standby,
    output logic                     cmd_valid,
    output logic                     cmd_reject,
    output logic                     proto_err,
    output logic [AW-1:0]            cmd_addr,
    output logic [DW-1:0]            cmd_data,
    output logic                     busy,
    output logic [$clog2(BANKS)-1:0] busy_bank
);
    import fbus_pkg::*;

    localparam int BW = $clog2(BANKS);
    localparam int SW = 3 + AW + DW;
    localparam int CW = $clog2(AUTO_CYC + 1);
    localparam logic [SW-1:0] SYNC_RST = {3'b111, {(AW + DW){1'b0}}};

    // Synchronised view of the host bus
    logic [SW-1:0] sync_q;
    logic          s_ce, s_we, s_oe;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;

    fbus_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n, addr, data_in}),
        .q     (sync_q)
    );
    assign {s_ce, s_we, s_oe, s_addr, s_data} = sync_q;

    bus_state_t state_q, state_d;
    logic       oe_bad;
    logic [CW-1:0] idle_cnt;
    logic       conflict;
    logic       page_hit;
    logic [DW-1:0] page_word;

    fbus_bank #(.BW(BW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (op_start),
        .done       (op_done),
        .start_bank (cmd_addr[AW-1 -: BW]),
        .busy       (busy),
        .busy_bank  (busy_bank)
    );

    fbus_page #(.AW(AW), .DW(DW)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill_en (state_q == S_READ),
        .rd_addr (s_addr),
        .hit     (page_hit),
        .rd_word (page_word)
    );

    // Next-state choice from the synchronised strobes
    always_comb begin
        if (s_ce)       state_d = S_STBY;
        else if (!s_we) state_d = S_WRITE;
        else if (!s_oe) state_d = S_READ;
        else            state_d = S_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_STBY;
        else        state_q <= state_d;
    end

    assign conflict = busy && (cmd_addr[AW-1 -: BW] != busy_bank);

    // Write capture, result pulses and idle counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_reject <= 1'b0;
            proto_err  <= 1'b0;
            cmd_addr   <= '0;
            cmd_data   <= '0;
            oe_bad     <= 1'b0;
            idle_cnt   <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            cmd_reject <= 1'b0;
            proto_err  <= 1'b0;
            unique case (state_q)
                S_WRITE: begin
                    if (state_d == S_WRITE) begin
                        oe_bad <= oe_bad | ~s_oe;
                    end else begin
                        cmd_data <= s_data;
                        if (oe_bad)        proto_err  <= 1'b1;
                        else if (conflict) cmd_reject <= 1'b1;
                        else               cmd_valid  <= 1'b1;
                    end
                end
                S_STBY, S_IDLE, S_READ: begin
                    if (state_d == S_WRITE) begin
                        cmd_addr <= s_addr;
                        oe_bad   <= ~s_oe;
                    end
                end
            endcase
            if (state_d == S_IDLE && state_q == S_IDLE)
                idle_cnt <= (idle_cnt == CW'(AUTO_CYC)) ? idle_cnt : idle_cnt + 1'b1;
            else
                idle_cnt <= '0;
        end
    end

    // Bus-facing outputs
    always_comb begin
        data_oe  = (state_q == S_READ);
        data_rdy = data_oe && page_hit;
        standby  = (state_q == S_STBY) ||
                   (state_q == S_IDLE && idle_cnt == CW'(AUTO_CYC));
        if (!data_rdy)
            data_out = '0;
        else if (busy && s_addr[AW-1 -: BW] == busy_bank)
            data_out = BUSY_WORD;
        else
            data_out = page_word;
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, cmd_reject, proto_err})); // R3
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || cmd_reject || proto_err) |=> !(cmd_valid || cmd_reject || proto_err)); // R3
    AST_STBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !data_oe); // R6
    AST_RDY_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> data_oe); // R5
    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $past(busy)); // R10
endmodule

// File: tb/fbus_front_tb.sv
module fbus_front_tb;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int AUTO = 16;
    localparam logic [15:0] BUSYW = 16'h0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic op_start = 1'b0, op_done = 1'b0;
    logic [DW-1:0] data_out, cmd_data;
    logic [AW-1:0] cmd_addr;
    logic data_oe, data_rdy, standby, cmd_valid, cmd_reject, proto_err, busy;
    logic [1:0] busy_bank;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    fbus_front u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data_in(data_in), .op_start(op_start), .op_done(op_done),
        .data_out(data_out), .data_oe(data_oe), .data_rdy(data_rdy),
        .standby(standby), .cmd_valid(cmd_valid), .cmd_reject(cmd_reject),
        .proto_err(proto_err), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .busy_bank(busy_bank)
    );

    // Reference model state (0 standby, 1 idle, 2 read, 3 write)
    int m_st;
    int m_cnt;
    bit m_oebad, m_pv, m_busy, m_cv, m_rej, m_err;
    int m_tag, m_bbank, m_caddr, m_cdata;
    int h_ce[$], h_we[$], h_oe[$], h_a[$], h_d[$];

    function automatic int word_of(int a);
        return (a * 40503 + 4660) & 16'hFFFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(int ce, int we, int oe);
        if (ce) return 0;
        if (!we) return 3;
        if (!oe) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        int ce2, we2, oe2, a2, d2, nst;
        bit conf;
        int exp_oe, exp_rdy, exp_out, exp_sb;
        string dtag;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_oebad = 0; m_pv = 0; m_busy = 0;
            m_cv = 0; m_rej = 0; m_err = 0; m_tag = 0; m_bbank = 0;
            m_caddr = 0; m_cdata = 0;
            h_ce = '{1, 1}; h_we = '{1, 1}; h_oe = '{1, 1};
            h_a = '{0, 0}; h_d = '{0, 0};
        end else begin
            // effective bus view: the sample taken two edges back (R1)
            ce2 = h_ce[0]; we2 = h_we[0]; oe2 = h_oe[0]; a2 = h_a[0]; d2 = h_d[0];
            nst = pick(ce2, we2, oe2);
            conf = m_busy && ((m_caddr >> 6) != m_bbank);
            m_cv = 0; m_rej = 0; m_err = 0;
            if (m_st == 2 && !(m_pv && m_tag == (a2 >> 3))) begin
                m_pv = 1; m_tag = a2 >> 3;
            end
            if (m_st == 3) begin
                if (nst == 3) m_oebad = m_oebad | (oe2 == 0);
                else begin
                    m_cdata = d2;
                    if (m_oebad) m_err = 1;
                    else if (conf) m_rej = 1;
                    else m_cv = 1;
                end
            end else if (nst == 3) begin
                m_caddr = a2; m_oebad = (oe2 == 0);
            end
            if (op_done) m_busy = 0;
            else if (op_start && !m_busy) begin m_busy = 1; m_bbank = m_caddr >> 6; end
            m_cnt = (nst == 1 && m_st == 1) ? ((m_cnt < AUTO) ? m_cnt + 1 : m_cnt) : 0;
            m_st = nst;
            void'(h_ce.pop_front()); void'(h_we.pop_front()); void'(h_oe.pop_front());
            void'(h_a.pop_front()); void'(h_d.pop_front());
            h_ce.push_back(ce_n); h_we.push_back(we_n); h_oe.push_back(oe_n);
            h_a.push_back(addr); h_d.push_back(data_in);
        end
        #2;
        if (!done_flag) begin
            a2 = h_a[0];
            exp_oe = (m_st == 2);
            exp_rdy = exp_oe && m_pv && (m_tag == (a2 >> 3));
            exp_sb = (m_st == 0) || (m_st == 1 && m_cnt == AUTO);
            if (!exp_rdy) begin exp_out = 0; dtag = "R7"; end
            else if (m_busy && (a2 >> 6) == m_bbank) begin exp_out = BUSYW; dtag = "R9"; end
            else begin
                exp_out = word_of((m_tag << 3) | (a2 & 7));
                dtag = m_busy ? "R8" : "R7";
            end
            check("R5 data_oe (R1 lag)", data_oe, exp_oe);
            check("R7 data_rdy", data_rdy, exp_rdy);
            check({dtag, " data_out"}, data_out, exp_out);
            check("R6 standby", standby, exp_sb);
            check("R3 cmd_valid", cmd_valid, m_cv);
            check("R3 cmd_data", cmd_data, m_cdata);
            check("R2 cmd_addr", cmd_addr, m_caddr);
            check("R4 proto_err", proto_err, m_err);
            check("R10 cmd_reject", cmd_reject, m_rej);
            check("R11 busy", busy, m_busy);
            if (m_busy) check("R11 busy_bank", busy_bank, m_bbank);
        end
    end

    task automatic bus(input logic c, input logic w, input logic o,
                       input int a, input int d, input int n);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = AW'(a); data_in = DW'(d);
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic pulse_ops(input logic s, input logic e);
        @(negedge clk); op_start = s; op_done = e;
        @(negedge clk); op_start = 0; op_done = 0;
    endtask

    // plain write: both low with address, then release, then park
    task automatic wr(input int a, input int d, input logic o);
        bus(1'b0, 1'b0, o, a, d, 5);
        bus(1'b0, 1'b1, 1'b1, a, d, 3);
        bus(1'b1, 1'b1, 1'b1, 0, 0, 4);
    endtask

    task automatic rd(input int a, input int n);
        bus(1'b0, 1'b1, 1'b0, a, 0, n);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        bus(1, 1, 1, 0, 0, 5);                  // R6 standby on chip enable high
        bus(0, 1, 1, 0, 0, AUTO + 8);           // R6 automatic standby
        rd(8'h12, 6); rd(8'h15, 4); rd(8'h2A, 6); // R7 fill, hit, reload
        bus(0, 1, 1, 8'h2A, 0, 3);              // R5 output enable high
        bus(1, 1, 1, 0, 0, 3);
        wr(8'h40, 16'hBEEF, 1);                 // R2 R3 accepted write
        bus(1, 0, 1, 8'h81, 16'h1111, 4);       // R2 write enable first
        bus(0, 0, 1, 8'h85, 16'h1111, 4);       // chip enable falls last
        bus(0, 0, 1, 8'h85, 16'h1234, 2);
        bus(1, 0, 1, 8'h85, 16'h1234, 3);       // R3 chip enable rises first
        bus(1, 1, 1, 0, 0, 4);
        wr(8'h10, 16'h5555, 0);                 // R4 output enable low
        wr(8'hC3, 16'h00AA, 1);
        pulse_ops(1, 0);                        // R11 bank 3 busy
        rd(8'hC1, 6);                           // R9 busy bank status
        rd(8'h21, 6);                           // R8 other bank data
        bus(1, 1, 1, 0, 0, 3);
        wr(8'h22, 16'h7777, 1);                 // R10 rejected
        wr(8'hC8, 16'h8888, 1);                 // R10 accepted in busy bank
        wr(8'h05, 16'h9999, 1);                 // cmd_addr now in bank 0
        pulse_ops(1, 0);                        // R11 ignored while busy
        pulse_ops(1, 1);                        // R11 done wins
        rd(8'hC1, 6);                           // R7 data after release
        bus(1, 1, 1, 0, 0, 4);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_bad++;
        done_flag = 1;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule